// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop is locked. Once per phase comparison it receives a strobe and a flag. The flag says whether the measured phase error was below the acceptance threshold. The block drives a single lock indication with hysteresis. The indication is raised only after a run of good comparisons and dropped only after a run of bad ones. The run length is set by a two-bit window select. Measuring the phase error happens upstream and is outside this block.

Each new frequency setting forces the detector back to the unlocked state, so software always sees lock lost at a retune. A bypass mode routes the raw phase-detector pulse straight to the lock output for analog observation. A power-down input holds the output low and keeps the detector cleared.

Top module: `pll_lock_monitor`

## Requirements
- R1: After a synchronous reset `lock_o` is 0, and the detector is unlocked with an empty run count.
- R2: `win_sel` picks the run length N = 2^(sel+3) - 1: 0 gives 7, 1 gives 15, 2 gives 31, 3 gives 63.
- R3: While unlocked, the digital result goes to 1 on the clock edge that samples the Nth consecutive comparison with `err_small` = 1.
- R4: While locked, the digital result goes to 0 on the clock edge that samples the Nth consecutive comparison with `err_small` = 0.
- R5: A comparison of the kind that matches the present state (good while locked, bad while unlocked) restarts the run count from zero.
- R6: Cycles with `cmp_valid` = 0 leave both the run count and the state unchanged, whatever `err_small` is.
- R7: `freq_commit` = 1 forces the unlocked state and clears the run count on that edge. It takes priority over a comparison in the same cycle.
- R8: A change of `win_sel` takes effect at the next comparison and does not clear the count. If the count already reaches the new N, the next matching comparison causes the transition.
- R9: With `raw_mode` = 1, `lock_o` follows `pfd_raw` combinationally while the digital detector keeps running. With `raw_mode` = 0, `lock_o` shows the digital result.
- R10: With `pwr_dn` = 1, `lock_o` is 0 combinationally and the detector is cleared to unlocked on each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | One-cycle strobe per phase comparison |
| err_small | input | 1 | 1 when the phase error of this comparison is below the threshold |
| win_sel | input | 2 | Run-length select (N = 7, 15, 31, 63) |
| raw_mode | input | 1 | 1 routes the raw phase-detector pulse to the output |
| pfd_raw | input | 1 | Raw phase-detector activity |
| freq_commit | input | 1 | Strobe marking a new frequency setting |
| pwr_dn | input | 1 | Power-down, forces the output low |
| lock_o | output | 1 | Lock indication |

## Verification
The digital result is registered. It changes on the rising edge that samples the deciding comparison, so the bench drives every stimulus on a falling edge and reads `lock_o` on the next falling edge, one edge later. The bypass and power-down paths have no register. They are read 1 ns after the inputs change, with no clock edge in between. Run-length boundaries are checked at N-1 (no change) and at N (change), for every window size. Clearing by a retune and by power-down is shown by a later run that needs the full N again.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    localparam int LD_SEL_W     = 2;
    localparam int LD_BASE_LOG2 = 3;
    localparam int LD_CNT_W     = LD_BASE_LOG2 + (1 << LD_SEL_W) - 1;

    typedef enum logic {
        LK_UNLOCKED = 1'b0,
        LK_LOCKED   = 1'b1
    } lk_state_e;

    typedef struct packed {
        logic step;     // comparison pushes toward the other state
        logic restart;  // comparison confirms the present state
    } cmp_evt_t;

    function automatic logic [LD_CNT_W-1:0] run_limit(input logic [LD_SEL_W-1:0] sel);
        int unsigned v;
        v = (32'd1 << (LD_BASE_LOG2 + int'(sel))) - 32'd1;
        return v[LD_CNT_W-1:0];
    endfunction

endpackage

// File: rtl/lockdet_classify.sv
module lockdet_classify
    import lockdet_pkg::*;
(
    input  lk_state_e state_q,
    input  logic      cmp_valid,
    input  logic      err_small,
    output cmp_evt_t  evt
);
    logic toward;

    always_comb begin
        toward      = (state_q == LK_LOCKED) ? !err_small : err_small;
        evt.step    = cmp_valid && toward;
        evt.restart = cmp_valid && !toward;
    end
endmodule

// File: rtl/lockdet_run_cnt.sv
module lockdet_run_cnt
    import lockdet_pkg::*;
#(
    parameter int SEL_W = LD_SEL_W,
    parameter int CNT_W = LD_CNT_W
) (
    input  logic             clk,
    input  logic             clr,
    input  cmp_evt_t         evt,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] cnt_inc;
    logic [EXT_W-1:0] limit_ext;

    always_comb begin
        cnt_inc   = {1'b0, cnt_q} + EXT_W'(1);
        limit_ext = {1'b0, run_limit(sel)};
        hit       = evt.step && (cnt_inc >= limit_ext);
    end

    always_ff @(posedge clk) begin
        if (clr || hit || evt.restart) begin
            cnt_q <= '0;
        end else if (evt.step) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/lockdet_state.sv
module lockdet_state
    import lockdet_pkg::*;
(
    input  logic      clk,
    input  logic      clr,
    input  logic      hit,
    output lk_state_e state_q
);
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= LK_UNLOCKED;
        end else if (hit) begin
            state_q <= (state_q == LK_LOCKED) ? LK_UNLOCKED : LK_LOCKED;
        end
    end
endmodule

// File: rtl/lockdet_out_sel.sv
module lockdet_out_sel
    import lockdet_pkg::*;
(
    input  lk_state_e state_q,
    input  logic      raw_mode,
    input  logic      pfd_raw,
    input  logic      pwr_dn,
    output logic      lock_o
);
    always_comb begin
        if (pwr_dn) begin
            lock_o = 1'b0;
        end else if (raw_mode) begin
            lock_o = pfd_raw;
        end else begin
            lock_o = (state_q == LK_LOCKED);
        end
    end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import lockdet_pkg::*;
#(
    parameter int SEL_W = LD_SEL_W,
    parameter int CNT_W = LD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_valid,
    input  logic             err_small,
    input  logic [SEL_W-1:0] win_sel,
    input  logic             raw_mode,
    input  logic             pfd_raw,
    input  logic             freq_commit,
    input  logic             pwr_dn,
    output logic             lock_o
);
    lk_state_e        state_q;
    cmp_evt_t         evt;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             clr;

    assign clr = rst || freq_commit || pwr_dn;

    lockdet_classify u_cls (
        .state_q   (state_q),
        .cmp_valid (cmp_valid),
        .err_small (err_small),
        .evt       (evt)
    );

    lockdet_run_cnt #(
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .clr   (clr),
        .evt   (evt),
        .sel   (win_sel),
        .cnt_q (cnt_q),
        .hit   (hit)
    );

    lockdet_state u_st (
        .clk     (clk),
        .clr     (clr),
        .hit     (hit),
        .state_q (state_q)
    );

    lockdet_out_sel u_out (
        .state_q  (state_q),
        .raw_mode (raw_mode),
        .pfd_raw  (pfd_raw),
        .pwr_dn   (pwr_dn),
        .lock_o   (lock_o)
    );
endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk
    import lockdet_pkg::*;
#(
    parameter int CNT_W = LD_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             cmp_valid,
    input logic             err_small,
    input logic             raw_mode,
    input logic             pfd_raw,
    input logic             freq_commit,
    input logic             pwr_dn,
    input logic             lock_o,
    input lk_state_e        state_q,
    input logic [CNT_W-1:0] cnt_q
);
    logic locked;
    assign locked = (state_q == LK_LOCKED);

    // R3
    lock_rise_needs_good_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(cmp_valid && err_small));

    // R4
    lock_fall_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(freq_commit || pwr_dn || (cmp_valid && !err_small)));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmp_valid && !freq_commit && !pwr_dn) |=> ($stable(cnt_q) && $stable(locked)));

    // R7
    commit_clears_chk: assert property (@(posedge clk) disable iff (rst)
        freq_commit |=> (!locked && cnt_q == '0));

    // R9
    raw_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_mode && !pwr_dn) |-> (lock_o == pfd_raw));

    // R10
    pwr_low_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |-> !lock_o);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q != '1);
endmodule

bind pll_lock_monitor lockdet_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmp_valid   (cmp_valid),
    .err_small   (err_small),
    .raw_mode    (raw_mode),
    .pfd_raw     (pfd_raw),
    .freq_commit (freq_commit),
    .pwr_dn      (pwr_dn),
    .lock_o      (lock_o),
    .state_q     (state_q),
    .cnt_q       (cnt_q)
);

// File: tb/sim_pll_lock_monitor.sv
`timescale 1ns/1ps
module sim_pll_lock_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_valid = 1'b0;
    logic       err_small = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic       raw_mode = 1'b0;
    logic       pfd_raw = 1'b0;
    logic       freq_commit = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       lock_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pll_lock_monitor u0 (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .err_small(err_small),
        .win_sel(win_sel), .raw_mode(raw_mode), .pfd_raw(pfd_raw),
        .freq_commit(freq_commit), .pwr_dn(pwr_dn), .lock_o(lock_o)
    );

    // vector: [12:11] cmd (0 idle, 1 compare, 2 commit), [10:9] sel, [8] err_small,
    //         [7:1] repeat count, [0] expected lock_o after the last repeat
    function automatic logic [12:0] mk(input int cmd, input int sel, input int err,
                                       input int rep, input int exp_v);
        return {cmd[1:0], sel[1:0], err[0], rep[6:0], exp_v[0]};
    endfunction

    localparam int NV = 21;
    localparam logic [12:0] VEC [NV] = '{
        mk(1, 0, 1, 6,  0),  // R3 N-1 good, N=7
        mk(1, 0, 1, 1,  1),  // R3 Nth good locks
        mk(1, 0, 0, 6,  1),  // R4 N-1 bad
        mk(1, 0, 1, 1,  1),  // R5 good while locked restarts
        mk(1, 0, 0, 6,  1),  // R5 run begins again
        mk(1, 0, 0, 1,  0),  // R4 Nth bad unlocks
        mk(0, 0, 1, 5,  0),  // R6 idle with err_small high
        mk(1, 0, 1, 3,  0),  // R6 partial run
        mk(0, 0, 0, 4,  0),  // R6 idle gap
        mk(1, 0, 1, 4,  1),  // R6 count kept across gap: 3+4=7
        mk(1, 1, 0, 14, 1),  // R2 N=15 minus one
        mk(1, 1, 0, 1,  0),  // R2 N=15 reached
        mk(1, 2, 1, 30, 0),  // R2 N=31 minus one
        mk(1, 2, 1, 1,  1),  // R2 N=31 reached
        mk(1, 3, 0, 62, 1),  // R2 N=63 minus one
        mk(1, 3, 0, 1,  0),  // R2 N=63 reached
        mk(1, 3, 1, 40, 0),  // R7 partial run before retune
        mk(2, 3, 0, 1,  0),  // R7 retune clears
        mk(1, 0, 1, 6,  0),  // R7 full N needed again
        mk(1, 0, 1, 1,  1),  // R7 lock after fresh run
        mk(2, 0, 0, 1,  0)   // R7 retune drops lock
    };

    task automatic check(input string tag, input logic got, input logic exp_v);
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: lock_o=%0b expected %0b", tag, got, exp_v);
        end
    endtask

    task automatic drive(input int cmd, input int sel, input int err, input int rep);
        for (int i = 0; i < rep; i++) begin
            win_sel     = sel[1:0];
            err_small   = err[0];
            cmp_valid   = (cmd == 1);
            freq_commit = (cmd == 2);
            @(negedge clk);
        end
        cmp_valid   = 1'b0;
        freq_commit = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run hung, lock_o=%0b expected completion", lock_o);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset state", lock_o, 1'b0);

        for (int v = 0; v < NV; v++) begin
            drive(int'(VEC[v][12:11]), int'(VEC[v][10:9]), int'(VEC[v][8]), int'(VEC[v][7:1]));
            check($sformatf("vector row %0d", v), lock_o, VEC[v][0]);
        end

        // R8: N lowered mid-run, count 20 already beyond new N=7
        do_reset();
        drive(1, 3, 1, 20);
        check("R8 no lock at 20 of 63", lock_o, 1'b0);
        drive(1, 0, 1, 1);
        check("R8 new N applies without clearing", lock_o, 1'b1);

        // R7: retune and comparison in the same cycle
        do_reset();
        drive(1, 0, 1, 6);
        win_sel = 2'd0; cmp_valid = 1'b1; err_small = 1'b1; freq_commit = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0; freq_commit = 1'b0;
        check("R7 commit beats comparison", lock_o, 1'b0);
        drive(1, 0, 1, 6);
        check("R7 count restarted", lock_o, 1'b0);
        drive(1, 0, 1, 1);
        check("R7 lock after full run", lock_o, 1'b1);

        // R9: bypass follows raw pulse, detector keeps running
        raw_mode = 1'b1; pfd_raw = 1'b0; #1;
        check("R9 raw low", lock_o, 1'b0);
        pfd_raw = 1'b1; #1;
        check("R9 raw high", lock_o, 1'b1);
        @(negedge clk);
        drive(1, 0, 0, 7);
        check("R9 raw still shown", lock_o, 1'b1);
        raw_mode = 1'b0; #1;
        check("R9 digital unlocked behind bypass", lock_o, 1'b0);
        pfd_raw = 1'b0;

        // R10: power-down
        @(negedge clk);
        drive(1, 0, 1, 7);
        check("R10 locked before power-down", lock_o, 1'b1);
        pwr_dn = 1'b1; #1;
        check("R10 forced low", lock_o, 1'b0);
        raw_mode = 1'b1; pfd_raw = 1'b1; #1;
        check("R10 low over bypass", lock_o, 1'b0);
        @(negedge clk);
        pwr_dn = 1'b0; raw_mode = 1'b0; pfd_raw = 1'b0; #1;
        check("R10 detector cleared", lock_o, 1'b0);

        // R1: reset while locked
        @(negedge clk);
        drive(1, 0, 1, 7);
        check("R1 locked before reset", lock_o, 1'b1);
        do_reset();
        check("R1 reset drops lock", lock_o, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule